// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one direction of a DMA channel that walks a chain of descriptors kept in memory. Each descriptor is three consecutive 32-bit words: a pointer to the next descriptor, the address of a data buffer and a byte count. The host gives a base address and pulses an initialise strobe. The channel then reads the descriptor, streams the buffer out one 32-bit word per beat, and moves on to the next descriptor in the chain.

The host bounds the walk with a limit register that holds the address of the last descriptor the channel may process. Once a descriptor's data has been fully delivered, the channel compares its current descriptor address with the limit. If they differ, it follows the next pointer. If they match, it parks in a suspended state and issues no memory traffic. A later write to the limit register wakes it. It compares again and, on a mismatch, reads the next pointer of the parked descriptor from memory again, so a chain that was extended after the channel parked is followed. The current descriptor address is always visible to the host, so software can track progress.

Top module: `ll_desc_dma`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `cur_addr_o` is 0, and neither `mreq_valid_o` nor `st_valid_o` is asserted.
- R2: An `init_i` pulse while idle or suspended copies `base_addr_i` into `cur_addr_o` and starts a descriptor fetch there. An `init_i` pulse during fetch, transfer, compare or refetch is ignored, and the current address and the data stream are unaffected.
- R3: A descriptor fetch reads three words in order, at cur, cur+4 and cur+8. These hold the next pointer, the buffer address and the byte count in bits [15:0]. Bits [31:16] of the count word are ignored.
- R4: For a nonzero count N, the channel reads buffer, buffer+4, … (ceil(N/4) words in ascending order) and emits each response word unchanged as one stream beat, in the same order.
- R5: Every beat except the last has `st_last_o`=0 and `st_bytes_o`=4. The last beat has `st_last_o`=1 and `st_bytes_o`=N−4·(ceil(N/4)−1), a value from 1 to 4.
- R6: At most one memory read is outstanding. A request holds `mreq_valid_o` and `mreq_addr_o` steady until `mreq_ready_i` accepts it.
- R7: While a beat is held without `st_ready_i`, the beat stays valid and unchanged, and no memory request is issued.
- R8: Once all beats of a descriptor are delivered, if `cur_addr_o` differs from the limit, the current address takes the fetched next pointer and a new descriptor fetch begins.
- R9: If the current address equals the limit at that point, `state_o` becomes 4 (suspended) and no memory request is made until the limit is written or `init_i` is pulsed.
- R10: A limit write while suspended triggers a new comparison. If the addresses now differ, the channel reads word 0 of the current descriptor again, takes that value as the new current address and fetches from there. If they are still equal, the channel stays suspended with no memory access.
- R11: A descriptor with count 0 issues no data read and no beat, and goes straight to the comparison.
- R12: A limit write while the channel is running is stored and used at the next comparison.
- R13: `state_o` encodes 0 idle, 1 fetch, 2 transfer, 3 compare, 4 suspended, 5 refetch. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Initialise strobe, one cycle |
| base_addr_i | input | 32 | Start descriptor address, used on init |
| last_wr_i | input | 1 | Limit register write strobe |
| last_addr_i | input | 32 | Limit descriptor address written on strobe |
| cur_addr_o | output | 32 | Current descriptor address |
| state_o | output | 3 | Channel state code |
| mreq_valid_o | output | 1 | Memory read request valid |
| mreq_ready_i | input | 1 | Memory read request accepted |
| mreq_addr_o | output | 32 | Memory read byte address |
| mrsp_valid_i | input | 1 | Memory read response valid |
| mrsp_data_i | input | 32 | Memory read response data |
| st_valid_o | output | 1 | Stream beat valid |
| st_ready_i | input | 1 | Stream sink ready |
| st_data_o | output | 32 | Stream beat data |
| st_last_o | output | 1 | Final beat of a descriptor |
| st_bytes_o | output | 3 | Valid byte count of the beat, 1 to 4 |

## Verification
The bench sweeps byte counts 0 to 9 across a three-descriptor chain. A wrong tail calculation would show up as an incorrect final-beat byte count or an extra or missing beat, and a bad zero-length path would issue a stray buffer read. It patches a parked descriptor's next pointer and then rewrites the limit. A design that reused its stale copy of the pointer would branch back to the head of the chain instead of to the new descriptor, and a design that did not suspend on a match would keep issuing reads. Limit and init strobes sent mid-transfer catch a design that applies the limit late or restarts on an ignored init. Throughout, ready and response stalls check that beats stay stable under backpressure and that reads never overlap.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH   = 3'd1,
        ST_XFER    = 3'd2,
        ST_CMP     = 3'd3,
        ST_SUSP    = 3'd4,
        ST_REFETCH = 3'd5
    } chan_st_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_REQ  = 2'd1,
        RD_WAIT = 2'd2
    } rd_ph_e;

endpackage

// File: rtl/ldma_len_calc.sv
module ldma_len_calc #(
    parameter int CNT_W = 16,
    parameter int BYTES = 4,
    parameter int BV_W  = 3
) (
    input  logic [CNT_W-1:0] rem_i,
    output logic [BV_W-1:0]  take_o,
    output logic             fin_o
);
    // bytes carried by the next beat and whether it ends the buffer
    always_comb begin
        if (rem_i >= CNT_W'(BYTES)) begin
            take_o = BV_W'(BYTES);
        end else begin
            take_o = rem_i[BV_W-1:0];
        end
        fin_o = (rem_i <= CNT_W'(BYTES));
    end
endmodule

// File: rtl/ldma_out_stage.sv
module ldma_out_stage #(
    parameter int DATA_W = 32,
    parameter int BV_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              last_i,
    input  logic [BV_W-1:0]   bytes_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o,
    output logic [BV_W-1:0]   bytes_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              last;
        logic [BV_W-1:0]   bytes;
    } beat_s;

    beat_s beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (beat_q.vld && ready_i) begin
            beat_d.vld = 1'b0;
        end
        if (ld_i) begin
            beat_d.vld   = 1'b1;
            beat_d.data  = data_i;
            beat_d.last  = last_i;
            beat_d.bytes = bytes_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign valid_o = beat_q.vld;
    assign data_o  = beat_q.data;
    assign last_o  = beat_q.last;
    assign bytes_o = beat_q.bytes;

    // R7: a stalled beat keeps its contents
    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o) && $stable(bytes_o)));

    // R7: nothing new is loaded over an undelivered beat
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i |-> (!valid_o || ready_i)));
endmodule

// File: rtl/ldma_chain_ctrl.sv
module ldma_chain_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int BV_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              last_wr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic [2:0]        st_o,
    output logic              mreq_valid_o,
    input  logic              mreq_ready_i,
    output logic [ADDR_W-1:0] mreq_addr_o,
    input  logic              mrsp_valid_i,
    input  logic [DATA_W-1:0] mrsp_data_i,
    input  logic              ob_full_i,
    input  logic [BV_W-1:0]   take_i,
    input  logic              fin_i,
    output logic [CNT_W-1:0]  rem_o,
    output logic              ld_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_last_o,
    output logic [BV_W-1:0]   ld_bytes_o
);
    import ldma_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int LG_B  = $clog2(BYTES);
    localparam logic [1:0] LAST_WIDX = 2'd2;

    typedef struct packed {
        chan_st_e          st;
        rd_ph_e            rd_ph;
        logic [ADDR_W-1:0] rd_addr;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] xaddr;
        logic [CNT_W-1:0]  rem;
        logic [1:0]        widx;
        logic              refetch;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;
    logic              rsp;
    logic [CNT_W-1:0]  rsp_cnt;
    logic [ADDR_W-1:0] rsp_addr;

    always_comb begin
        ctl_d    = ctl_q;
        ld_o     = 1'b0;
        rsp      = mrsp_valid_i && (ctl_q.rd_ph == RD_WAIT);
        rsp_cnt  = mrsp_data_i[CNT_W-1:0];
        rsp_addr = ADDR_W'(mrsp_data_i);

        // the limit register latches every host write, whatever the state
        if (last_wr_i) begin
            ctl_d.last = last_addr_i;
        end

        // read port phase
        if (ctl_q.rd_ph == RD_REQ && mreq_ready_i) begin
            ctl_d.rd_ph = RD_WAIT;
        end
        if (rsp) begin
            ctl_d.rd_ph = RD_NONE;
        end

        case (ctl_q.st)
            ST_IDLE: begin
                if (init_i) begin
                    ctl_d.cur  = base_i;
                    ctl_d.widx = 2'd0;
                    ctl_d.st   = ST_FETCH;
                end
            end

            ST_FETCH: begin
                if (ctl_q.rd_ph == RD_NONE) begin
                    ctl_d.rd_addr = ctl_q.cur + (ADDR_W'(ctl_q.widx) << LG_B);
                    ctl_d.rd_ph   = RD_REQ;
                end
                if (rsp) begin
                    case (ctl_q.widx)
                        2'd0:    ctl_d.nxt   = rsp_addr;
                        2'd1:    ctl_d.xaddr = rsp_addr;
                        default: ctl_d.rem   = rsp_cnt;
                    endcase
                    if (ctl_q.widx == LAST_WIDX) begin
                        ctl_d.widx = 2'd0;
                        ctl_d.st   = (rsp_cnt == '0) ? ST_CMP : ST_XFER;
                    end else begin
                        ctl_d.widx = ctl_q.widx + 2'd1;
                    end
                end
            end

            ST_XFER: begin
                if (rsp) begin
                    ld_o        = 1'b1;
                    ctl_d.rem   = ctl_q.rem - CNT_W'(take_i);
                    ctl_d.xaddr = ctl_q.xaddr + ADDR_W'(BYTES);
                end else if (ctl_q.rd_ph == RD_NONE && !ob_full_i) begin
                    if (ctl_q.rem != '0) begin
                        ctl_d.rd_addr = ctl_q.xaddr;
                        ctl_d.rd_ph   = RD_REQ;
                    end else begin
                        ctl_d.st = ST_CMP;
                    end
                end
            end

            ST_CMP: begin
                ctl_d.refetch = 1'b0;
                if (ctl_q.cur == ctl_q.last) begin
                    ctl_d.st = ST_SUSP;
                end else if (ctl_q.refetch) begin
                    ctl_d.st = ST_REFETCH;
                end else begin
                    ctl_d.cur  = ctl_q.nxt;
                    ctl_d.widx = 2'd0;
                    ctl_d.st   = ST_FETCH;
                end
            end

            ST_SUSP: begin
                if (init_i) begin
                    ctl_d.cur  = base_i;
                    ctl_d.widx = 2'd0;
                    ctl_d.st   = ST_FETCH;
                end else if (last_wr_i) begin
                    ctl_d.refetch = 1'b1;
                    ctl_d.st      = ST_CMP;
                end
            end

            ST_REFETCH: begin
                if (ctl_q.rd_ph == RD_NONE) begin
                    ctl_d.rd_addr = ctl_q.cur;
                    ctl_d.rd_ph   = RD_REQ;
                end
                if (rsp) begin
                    ctl_d.cur  = rsp_addr;
                    ctl_d.widx = 2'd0;
                    ctl_d.st   = ST_FETCH;
                end
            end

            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, rd_ph: RD_NONE, rd_addr: '0, cur: '0,
                       last: '0, nxt: '0, xaddr: '0, rem: '0, widx: '0,
                       refetch: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur_o        = ctl_q.cur;
    assign st_o         = ctl_q.st;
    assign mreq_valid_o = (ctl_q.rd_ph == RD_REQ);
    assign mreq_addr_o  = ctl_q.rd_addr;
    assign rem_o        = ctl_q.rem;
    assign ld_data_o    = mrsp_data_i;
    assign ld_last_o    = fin_i;
    assign ld_bytes_o   = take_i;

    // R6: an unaccepted request keeps valid and address
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o)));

    // R9: a parked channel makes no memory request
    assert_susp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SUSP) |-> !mreq_valid_o);

    // R7: a word is only handed on when the output stage has room
    assert_ld_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_o |-> !ob_full_i);

    // R2 and R8: the current address never moves during fetch or transfer
    assert_cur_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FETCH || ctl_q.st == ST_XFER) |=> $stable(cur_o));
endmodule

// File: rtl/ll_desc_dma.sv
module ll_desc_dma #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              last_wr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [2:0]        state_o,
    output logic              mreq_valid_o,
    input  logic              mreq_ready_i,
    output logic [ADDR_W-1:0] mreq_addr_o,
    input  logic              mrsp_valid_i,
    input  logic [DATA_W-1:0] mrsp_data_i,
    output logic              st_valid_o,
    input  logic              st_ready_i,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_last_o,
    output logic [$clog2(DATA_W/8):0] st_bytes_o
);
    localparam int BYTES = DATA_W / 8;
    localparam int BV_W  = $clog2(BYTES) + 1;

    logic [CNT_W-1:0]  rem;
    logic [BV_W-1:0]   take;
    logic              fin;
    logic              ld;
    logic [DATA_W-1:0] ld_data;
    logic              ld_last;
    logic [BV_W-1:0]   ld_bytes;

    ldma_len_calc #(.CNT_W(CNT_W), .BYTES(BYTES), .BV_W(BV_W)) u_len (
        .rem_i  (rem),
        .take_o (take),
        .fin_o  (fin)
    );

    ldma_chain_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BV_W(BV_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .base_i       (base_addr_i),
        .last_wr_i    (last_wr_i),
        .last_addr_i  (last_addr_i),
        .cur_o        (cur_addr_o),
        .st_o         (state_o),
        .mreq_valid_o (mreq_valid_o),
        .mreq_ready_i (mreq_ready_i),
        .mreq_addr_o  (mreq_addr_o),
        .mrsp_valid_i (mrsp_valid_i),
        .mrsp_data_i  (mrsp_data_i),
        .ob_full_i    (st_valid_o),
        .take_i       (take),
        .fin_i        (fin),
        .rem_o        (rem),
        .ld_o         (ld),
        .ld_data_o    (ld_data),
        .ld_last_o    (ld_last),
        .ld_bytes_o   (ld_bytes)
    );

    ldma_out_stage #(.DATA_W(DATA_W), .BV_W(BV_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (ld),
        .data_i  (ld_data),
        .last_i  (ld_last),
        .bytes_i (ld_bytes),
        .ready_i (st_ready_i),
        .valid_o (st_valid_o),
        .data_o  (st_data_o),
        .last_o  (st_last_o),
        .bytes_o (st_bytes_o)
    );

    // R5: inner beats are full words
    assert_full_inner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_o && !st_last_o) |-> (st_bytes_o == BV_W'(BYTES)));

    // R5: a beat never carries zero or more than a word of bytes
    assert_bytes_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o |-> (st_bytes_o != '0 && st_bytes_o <= BV_W'(BYTES)));

    // R13: only the six defined state codes appear
    assert_state_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd5);
endmodule

// File: tb/tb_ll_desc_dma.sv
module tb_ll_desc_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic [31:0] base_addr_i = '0;
    logic        last_wr_i = 1'b0;
    logic [31:0] last_addr_i = '0;
    logic [31:0] cur_addr_o;
    logic [2:0]  state_o;
    logic        mreq_valid_o;
    logic        mreq_ready_i = 1'b0;
    logic [31:0] mreq_addr_o;
    logic        mrsp_valid_i = 1'b0;
    logic [31:0] mrsp_data_i = '0;
    logic        st_valid_o;
    logic        st_ready_i = 1'b0;
    logic [31:0] st_data_o;
    logic        st_last_o;
    logic [2:0]  st_bytes_o;

    ll_desc_dma dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .base_addr_i(base_addr_i),
        .last_wr_i(last_wr_i), .last_addr_i(last_addr_i), .cur_addr_o(cur_addr_o),
        .state_o(state_o), .mreq_valid_o(mreq_valid_o), .mreq_ready_i(mreq_ready_i),
        .mreq_addr_o(mreq_addr_o), .mrsp_valid_i(mrsp_valid_i), .mrsp_data_i(mrsp_data_i),
        .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_data_o(st_data_o),
        .st_last_o(st_last_o), .st_bytes_o(st_bytes_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mem [0:255];
    logic [31:0] exp_addr[$], got_addr[$], exp_data[$], got_data[$];
    logic [3:0]  exp_tag[$], got_tag[$];
    int  cyc = 0;
    logic pend = 1'b0;
    int  dly = 0;
    logic [31:0] paddr = '0;
    int  viol_ovl = 0, viol_bp = 0, viol_stab = 0, viol_code = 0;
    logic prev_stall = 1'b0;
    logic [35:0] prev_beat = '0;
    logic [7:0] seen = '0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", state_o, 3'd4);
        summary();
    end

    // memory model and stream sink, all driven away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            mrsp_valid_i = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mrsp_valid_i = 1'b1;
                    mrsp_data_i  = mem[paddr[9:2]];
                    pend = 1'b0;
                end else begin
                    dly--;
                end
            end
            if (mreq_valid_o && (pend || mrsp_valid_i)) viol_ovl++;
            mreq_ready_i = (cyc % 3) != 1;
            if (mreq_valid_o && mreq_ready_i) begin
                got_addr.push_back(mreq_addr_o);
                pend  = 1'b1;
                paddr = mreq_addr_o;
                dly   = cyc % 3;
            end
            if (prev_stall && (!st_valid_o || {st_data_o, st_last_o, st_bytes_o} != prev_beat)) viol_stab++;
            if (st_valid_o && mreq_valid_o) viol_bp++;
            st_ready_i = ((cyc % 5) != 2) && ((cyc % 7) != 3);
            if (st_valid_o && st_ready_i) begin
                got_data.push_back(st_data_o);
                got_tag.push_back({st_last_o, st_bytes_o});
            end
            prev_stall = st_valid_o && !st_ready_i;
            prev_beat  = {st_data_o, st_last_o, st_bytes_o};
            if (state_o > 3'd5) viol_code++;
            else seen[state_o] = 1'b1;
        end
    end

    task automatic put_desc(input logic [31:0] d, input logic [31:0] nx, input logic [31:0] bf, input int cnt);
        mem[d[9:2]]       = nx;
        mem[d[9:2] + 8'd1] = bf;
        mem[d[9:2] + 8'd2] = {16'hC0DE, cnt[15:0]};
    endtask

    // expected requests and beats for one descriptor (R3, R4, R5, R11)
    task automatic expect_desc(input logic [31:0] d);
        logic [31:0] bf;
        int cnt, n;
        exp_addr.push_back(d);
        exp_addr.push_back(d + 32'd4);
        exp_addr.push_back(d + 32'd8);
        bf  = mem[d[9:2] + 8'd1];
        cnt = int'(mem[d[9:2] + 8'd2][15:0]);
        n   = (cnt + 3) / 4;
        for (int i = 0; i < n; i++) begin
            exp_addr.push_back(bf + 32'(4 * i));
            exp_data.push_back(pat(bf + 32'(4 * i)));
            if (i == n - 1) exp_tag.push_back({1'b1, 3'(cnt - 4 * (n - 1))});
            else            exp_tag.push_back({1'b0, 3'd4});
        end
    endtask

    task automatic cmp_logs(input string req);
        chk(got_addr.size() == exp_addr.size(), {req, " request count"}, got_addr.size(), exp_addr.size());
        for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++)
            chk(got_addr[i] == exp_addr[i], {req, " request address"}, got_addr[i], exp_addr[i]);
        chk(got_data.size() == exp_data.size(), {req, " beat count"}, got_data.size(), exp_data.size());
        for (int i = 0; i < exp_data.size() && i < got_data.size(); i++) begin
            chk(got_data[i] == exp_data[i], {req, " beat data"}, got_data[i], exp_data[i]);
            chk(got_tag[i] == exp_tag[i], {req, " beat last/bytes"}, 32'(got_tag[i]), 32'(exp_tag[i]));
        end
        exp_addr.delete(); got_addr.delete();
        exp_data.delete(); got_data.delete();
        exp_tag.delete();  got_tag.delete();
    endtask

    task automatic host_init(input logic [31:0] b);
        @(negedge clk);
        base_addr_i = b;
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
    endtask

    task automatic host_last(input logic [31:0] a);
        @(negedge clk);
        last_addr_i = a;
        last_wr_i = 1'b1;
        @(negedge clk);
        last_wr_i = 1'b0;
    endtask

    task automatic wait_state(input logic [2:0] s);
        while (state_o != s) @(negedge clk);
    endtask

    task automatic quiet_window(input string req);
        repeat (20) @(negedge clk);
        chk(got_addr.size() == 0, {req, " no request while parked"}, got_addr.size(), 0);
        chk(state_o == 3'd4, {req, " still suspended"}, state_o, 3'd4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(32'(i * 4));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(state_o == 3'd0, "R1 state after reset", state_o, 0);
        chk(cur_addr_o == 32'd0, "R1 current address after reset", cur_addr_o, 0);
        chk(!mreq_valid_o && !st_valid_o, "R1 no request or beat", {mreq_valid_o, st_valid_o}, 0);

        // sweep of counts over a three-descriptor chain: R2 R3 R4 R5 R8 R9 R11
        for (int c = 0; c < 10; c++) begin
            put_desc(32'h000, 32'h010, 32'h100, c);
            put_desc(32'h010, 32'h020, 32'h140, (c * 3 + 1) % 10);
            put_desc(32'h020, 32'h000, 32'h180, 9 - c);
            host_last(32'h020);
            repeat (3) @(negedge clk);
            exp_addr.delete(); got_addr.delete();
            expect_desc(32'h000);
            expect_desc(32'h010);
            expect_desc(32'h020);
            host_init(32'h000);
            wait_state(3'd4);
            chk(cur_addr_o == 32'h020, "R8/R9 parked at limit descriptor", cur_addr_o, 32'h020);
            cmp_logs("R3/R4/R5/R11 chain sweep");
            quiet_window("R9");
        end

        // patched pointer followed on resume: R10
        put_desc(32'h030, 32'h000, 32'h1C0, 7);
        mem[8'h08] = 32'h030;
        exp_addr.push_back(32'h020);
        expect_desc(32'h030);
        host_last(32'h030);
        wait_state(3'd4);
        chk(cur_addr_o == 32'h030, "R10 resumed to patched descriptor", cur_addr_o, 32'h030);
        cmp_logs("R10 refetch after limit write");
        host_last(32'h030);
        quiet_window("R10 equal limit rewrite");
        chk(cur_addr_o == 32'h030, "R10 address kept on equal rewrite", cur_addr_o, 32'h030);

        // running limit write and ignored init: R12 R2
        put_desc(32'h000, 32'h010, 32'h100, 40);
        put_desc(32'h010, 32'h020, 32'h140, 5);
        expect_desc(32'h000);
        expect_desc(32'h010);
        host_init(32'h000);
        wait_state(3'd2);
        host_last(32'h010);
        chk(state_o == 3'd2, "R2 precondition still transferring", state_o, 3'd2);
        host_init(32'h020);
        chk(cur_addr_o == 32'h000, "R2 init during transfer ignored", cur_addr_o, 32'h000);
        wait_state(3'd4);
        chk(cur_addr_o == 32'h010, "R12 stopped at newly written limit", cur_addr_o, 32'h010);
        cmp_logs("R12/R2 running limit write");

        // handshake invariants gathered across the run: R6 R7 R13
        chk(viol_ovl == 0, "R6 overlapping reads", viol_ovl, 0);
        chk(viol_stab == 0, "R7 stalled beat changed", viol_stab, 0);
        chk(viol_bp == 0, "R7 request while beat held", viol_bp, 0);
        chk(viol_code == 0, "R13 undefined state code", viol_code, 0);
        chk(seen[5:0] == 6'b111111, "R13 all state codes observed", seen, 8'h3F);
        summary();
    end
endmodule